// File: doc/BRIEF.md
# Bit-Serial AES Forward S-box

This block computes the AES forward substitution on a byte that arrives one bit per clock and leaves one bit per clock. It is meant to sit inside a bit-serial AES round datapath: the state store feeds it a bit stream, and the substituted bits go back into the stream toward the row and column mixing stages. A byte is collected in a capture shift register. When its last bit arrives, the byte is converted into a normal-basis representation of GF(2^8) and loaded into a rotating operand register.

In a normal basis, squaring is a cyclic rotation and the field inversion commutes with it. So one circuit that yields only the lowest normal-basis coordinate of the inverse can produce all eight coordinates, one per cycle, as the operand rotates. After eight such steps the collected coordinates go back to the polynomial basis. The affine output map is then applied, and the result is loaded into an output shift register that drives the serial output.

Capture of the next byte overlaps the evaluation of the current one, so a continuous input stream gives a continuous output stream.

Top module: `bitserial_sbox`

## Requirements
- R1: An input bit is taken only in a cycle where `bitInValid` is high. Bits arrive least-significant first, and every eighth taken bit closes a byte. The value of `bitIn` in a cycle with `bitInValid` low has no effect on any result.
- R2: Each byte's result leaves least-significant bit first, with `bitOutValid` high for exactly eight consecutive cycles per byte. `bitOut` is 0 whenever `bitOutValid` is low.
- R3: The eight output bits of a byte equal the AES forward S-box of the input byte, for all 256 values. This includes 0x00 giving 0x63, 0x01 giving 0x7C and 0x53 giving 0xED.
- R4: The first result bit is presented in the ninth cycle after the cycle that supplied the byte's last input bit. For a byte whose bits arrive in eight consecutive cycles, this is 16 cycles after its first bit.
- R5: Bytes fed back to back, with no idle input cycles, produce results back to back. `bitOutValid` stays high with no gap and each result starts on an eight-bit boundary.
- R6: While `rstN` is low and after its release, `bitOutValid` and `bitOut` are 0 until a byte has been completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| bitIn | input | 1 | Serial data bit, least-significant first |
| bitInValid | input | 1 | Qualifies `bitIn` in this cycle |
| bitOut | output | 1 | Serial substituted bit, least-significant first |
| bitOutValid | output | 1 | Qualifies `bitOut` in this cycle |

## Verification
The assertions assume that input bytes are completed at most once every eight cycles. This holds by construction, because one input bit comes per cycle. They place no other limit on how `bitInValid` may be gapped. The latency and alignment properties count taken input bits independently of the design's counters. The stimulus streams all 256 byte values contiguously to exercise the overlap of capture and evaluation. It then sends bytes with idle cycles inserted between bits, and drives random values on `bitIn` during those idle cycles. A lone byte followed by silence checks that the output burst ends after exactly eight bits.

// File: rtl/bitserial_sbox_pkg.sv
package bitserial_sbox_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] FIELD_POLY_LOW = 8'h1B;
  localparam logic [BYTE_W-1:0] AFFINE_CONST   = 8'h63;

  typedef logic [BYTE_W-1:0] gfByte_t;
  typedef gfByte_t [BYTE_W-1:0] gfCols_t;

  typedef struct packed {
    logic captureBit;
    logic loadOperand;
    logic evalStep;
    logic finishEval;
    logic shiftOut;
    logic outValid;
  } sboxCtl_t;

  function automatic gfByte_t gfMul(gfByte_t a, gfByte_t b);
    gfByte_t prod = '0;
    gfByte_t acc  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) prod = prod ^ acc;
      acc = acc[BYTE_W-1] ? ((acc << 1) ^ FIELD_POLY_LOW) : (acc << 1);
    end
    return prod;
  endfunction

  function automatic gfCols_t conjugates(gfByte_t b);
    gfCols_t c;
    c[0] = b;
    for (int i = 1; i < BYTE_W; i++) c[i] = gfMul(c[i-1], c[i-1]);
    return c;
  endfunction

  function automatic logic fullRank(gfCols_t v);
    gfCols_t m = v;
    gfByte_t t;
    int rank = 0;
    logic found;
    for (int col = 0; col < BYTE_W; col++) begin
      found = 1'b0;
      for (int row = 0; row < BYTE_W; row++) begin
        if (!found && row >= rank && m[row][col]) begin
          t = m[row]; m[row] = m[rank]; m[rank] = t; found = 1'b1;
        end
      end
      if (found) begin
        for (int row = 0; row < BYTE_W; row++)
          if (row != rank && m[row][col]) m[row] = m[row] ^ m[rank];
        rank++;
      end
    end
    return rank == BYTE_W;
  endfunction

  // Conjugates of the first element whose conjugates span the field.
  function automatic gfCols_t findNormalCols();
    gfCols_t best = '0;
    gfCols_t c;
    logic done = 1'b0;
    for (int cand = 1; cand < 256 && !done; cand++) begin
      c = conjugates(gfByte_t'(cand));
      if (fullRank(c)) begin
        best = c; done = 1'b1;
      end
    end
    return best;
  endfunction

  function automatic gfByte_t applyCols(gfCols_t cols, gfByte_t v);
    gfByte_t r = '0;
    for (int i = 0; i < BYTE_W; i++) if (v[i]) r = r ^ cols[i];
    return r;
  endfunction

  // Column k of the inverse map is the normal vector that maps to 2^k.
  function automatic gfCols_t invertCols(gfCols_t fwd);
    gfCols_t inv = '0;
    logic done;
    for (int k = 0; k < BYTE_W; k++) begin
      done = 1'b0;
      for (int a = 0; a < 256 && !done; a++) begin
        if (applyCols(fwd, gfByte_t'(a)) == gfByte_t'(1 << k)) begin
          inv[k] = gfByte_t'(a); done = 1'b1;
        end
      end
    end
    return inv;
  endfunction

  localparam gfCols_t NORM_TO_POLY = findNormalCols();
  localparam gfCols_t POLY_TO_NORM = invertCols(NORM_TO_POLY);

  function automatic gfByte_t gfInv(gfByte_t x);
    gfByte_t sq = x;
    gfByte_t r  = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      sq = gfMul(sq, sq);
      r  = gfMul(r, sq);
    end
    return r;
  endfunction

  // Lowest normal-basis coordinate of the inverse of a normal-basis operand.
  function automatic logic sStar(gfByte_t normOp);
    gfByte_t res = applyCols(POLY_TO_NORM, gfInv(applyCols(NORM_TO_POLY, normOp)));
    return res[0];
  endfunction

  function automatic gfByte_t affineOut(gfByte_t b);
    gfByte_t r = b ^ AFFINE_CONST;
    for (int s = 1; s <= 4; s++) r = r ^ ((b << s) | (b >> (BYTE_W - s)));
    return r;
  endfunction

endpackage

// File: rtl/bitserial_sbox_ctrl.sv
module bitserial_sbox_ctrl
  import bitserial_sbox_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitInValid,
  output sboxCtl_t ctl
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] inCnt, evalCnt, outCnt;
  logic evalBusy, outBusy;
  logic byteClosed, evalLast;

  assign byteClosed = bitInValid && (inCnt == LAST);
  assign evalLast   = evalBusy && (evalCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt <= '0;
    end else if (bitInValid) begin
      inCnt <= byteClosed ? '0 : inCnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evalBusy <= 1'b0;
      evalCnt  <= '0;
    end else if (byteClosed) begin
      evalBusy <= 1'b1;
      evalCnt  <= '0;
    end else if (evalBusy) begin
      if (evalLast) evalBusy <= 1'b0;
      evalCnt <= evalCnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBusy <= 1'b0;
      outCnt  <= '0;
    end else if (evalLast) begin
      outBusy <= 1'b1;
      outCnt  <= '0;
    end else if (outBusy) begin
      if (outCnt == LAST) outBusy <= 1'b0;
      outCnt <= outCnt + ONE;
    end
  end

  always_comb begin
    ctl.captureBit  = bitInValid;
    ctl.loadOperand = byteClosed;
    ctl.evalStep    = evalBusy;
    ctl.finishEval  = evalLast;
    ctl.shiftOut    = outBusy;
    ctl.outValid    = outBusy;
  end
endmodule

// File: rtl/bitserial_sbox_dp.sv
module bitserial_sbox_dp
  import bitserial_sbox_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitIn,
  input  sboxCtl_t ctl,
  output logic     bitOut
);
  gfByte_t captureReg;   // R1: incoming bits
  gfByte_t operandReg;   // R2: rotating normal-basis operand
  gfByte_t coordAcc;     // collected normal-basis coordinates
  gfByte_t outReg;
  gfByte_t fullByte, rotated, finalNorm;
  logic    coordBit;

  assign fullByte  = {bitIn, captureReg[BYTE_W-1:1]};
  assign coordBit  = sStar(operandReg);
  assign finalNorm = {coordBit, coordAcc[BYTE_W-1:1]};

  // Rotate toward bit 0: step j evaluates coordinate j of the inverse.
  for (genvar i = 0; i < BYTE_W; i++) begin : g_rot
    assign rotated[i] = operandReg[(i + 1) % BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      captureReg <= '0;
    end else if (ctl.captureBit) begin
      captureReg <= fullByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      operandReg <= '0;
    end else if (ctl.loadOperand) begin
      operandReg <= applyCols(POLY_TO_NORM, fullByte);
    end else if (ctl.evalStep) begin
      operandReg <= rotated;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coordAcc <= '0;
    end else if (ctl.evalStep) begin
      coordAcc <= finalNorm;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (ctl.finishEval) begin
      outReg <= affineOut(applyCols(NORM_TO_POLY, finalNorm));
    end else if (ctl.shiftOut) begin
      outReg <= {1'b0, outReg[BYTE_W-1:1]};
    end
  end

  assign bitOut = outReg[0] & ctl.outValid;
endmodule

// File: rtl/bitserial_sbox.sv
module bitserial_sbox
  import bitserial_sbox_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  input  logic bitInValid,
  output logic bitOut,
  output logic bitOutValid
);
  sboxCtl_t ctl;

  bitserial_sbox_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitInValid (bitInValid),
    .ctl        (ctl)
  );

  bitserial_sbox_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .bitIn  (bitIn),
    .ctl    (ctl),
    .bitOut (bitOut)
  );

  assign bitOutValid = ctl.outValid;
endmodule

// File: rtl/bitserial_sbox_chk.sv
module bitserial_sbox_chk (
  input logic clk,
  input logic rstN,
  input logic bitInValid,
  input logic bitOut,
  input logic bitOutValid
);
  logic [2:0] inBits;
  logic [2:0] outMod;
  logic [8:0] doneHist;
  logic       byteDone;

  assign byteDone = bitInValid && (inBits == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBits   <= '0;
      outMod   <= '0;
      doneHist <= '0;
    end else begin
      if (bitInValid) inBits <= inBits + 3'd1;
      if (bitOutValid) outMod <= outMod + 3'd1;
      doneHist <= {doneHist[7:0], byteDone};
    end
  end

  AST_OUT_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !bitOutValid |-> !bitOut); // R2

  AST_RUN_WHOLE_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bitOutValid) |-> (outMod == 3'd0)); // R2

  AST_OUT_ON_TIME: assert property (@(posedge clk) disable iff (!rstN)
    doneHist[8] |-> bitOutValid); // R4

  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitOutValid) |-> doneHist[8]); // R4

  AST_BYTE_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    doneHist[8] |-> (outMod == 3'd0)); // R5

  AST_IDLE_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (doneHist == 9'd0 && !bitOutValid) |=> (!bitOutValid || $past(byteDone, 8) || doneHist[8])); // R6
endmodule

bind bitserial_sbox bitserial_sbox_chk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .bitInValid  (bitInValid),
  .bitOut      (bitOut),
  .bitOutValid (bitOutValid)
);

// File: tb/bitserial_sbox_test.sv
module bitserial_sbox_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitIn = 1'b0;
  logic bitInValid = 1'b0;
  logic bitOut, bitOutValid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [7:0] refTab [256];
  logic [7:0] expQ [$];
  int         dueQ [$];
  string      tagQ [$];

  bitserial_sbox uut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitInValid(bitInValid),
    .bitOut(bitOut), .bitOutValid(bitOutValid)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] refMul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] refSbox(logic [7:0] v);
    logic [7:0] inv = 8'h00;
    logic [7:0] s;
    logic [7:0] c = 8'h63;
    for (int k = 1; k < 256; k++)
      if (v != 8'h00 && refMul(v, 8'(k)) == 8'h01) inv = 8'(k);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: serializes a byte, optionally with idle cycles carrying junk (R1).
  task automatic sendByte(input logic [7:0] v, input bit gaps, input string tag);
    for (int k = 0; k < 8; k++) begin
      if (gaps && (k % 3 == 1)) begin
        for (int g = 0; g < 2; g++) begin
          @(negedge clk);
          bitInValid = 1'b0;
          bitIn = 1'($urandom);
        end
      end
      @(negedge clk);
      bitInValid = 1'b1;
      bitIn = v[k];
      if (k == 7) begin
        expQ.push_back(refTab[v]);
        dueQ.push_back(cyc + 9);
        tagQ.push_back(tag);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitInValid = 1'b0;
      bitIn = 1'($urandom);
    end
  endtask

  // Monitor: deserializes results and compares them with the queue.
  int bitIdx = 0;
  logic [7:0] gotByte;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (bitOutValid) begin
        if (bitIdx == 0) begin
          if (dueQ.size() == 0) begin
            check(1'b0, "R2 unexpected output", 1, 0);
          end else begin
            check(cyc == dueQ[0], "R4 R5 start cycle", cyc, dueQ[0]);
          end
        end
        gotByte[bitIdx] = bitOut;
        if (bitIdx == 7) begin
          if (expQ.size() != 0) begin
            check(gotByte == expQ[0], {tagQ[0], " sbox value"}, gotByte, expQ[0]);
            void'(expQ.pop_front());
            void'(dueQ.pop_front());
            void'(tagQ.pop_front());
          end
          bitIdx = 0;
        end else begin
          bitIdx = bitIdx + 1;
        end
      end else begin
        check(bitIdx == 0, "R2 burst cut short", bitIdx, 0);
        if (bitOut) check(1'b0, "R2 bitOut high while invalid", 1, 0);
      end
    end
  end

  initial begin
    for (int v = 0; v < 256; v++) refTab[v] = refSbox(8'(v));
    // Known anchors of the reference itself (R3).
    check(refTab[8'h00] == 8'h63, "R3 ref 00", refTab[8'h00], 8'h63);
    check(refTab[8'h01] == 8'h7C, "R3 ref 01", refTab[8'h01], 8'h7C);
    check(refTab[8'h53] == 8'hED, "R3 ref 53", refTab[8'h53], 8'hED);

    repeat (3) @(negedge clk);
    check(bitOutValid == 1'b0 && bitOut == 1'b0, "R6 in reset", {bitOutValid, bitOut}, 0);
    rstN = 1'b1;
    idle(5);
    check(bitOutValid == 1'b0 && bitOut == 1'b0, "R6 after reset", {bitOutValid, bitOut}, 0);

    // Anchors through the design, then every value back to back (R3 R5).
    sendByte(8'h00, 1'b0, "R3");
    sendByte(8'h01, 1'b0, "R3");
    sendByte(8'h53, 1'b0, "R3");
    for (int v = 0; v < 256; v++) sendByte(8'(v), 1'b0, "R3 R5");
    idle(30);
    check(expQ.size() == 0, "R5 stream drained", expQ.size(), 0);

    // Gapped input with junk on bitIn while invalid (R1).
    for (int v = 0; v < 24; v++) sendByte(8'((v * 37 + 11) & 255), 1'b1, "R1");
    idle(30);

    // Lone byte, then silence: burst must end after eight bits (R2).
    sendByte(8'hA5, 1'b0, "R2");
    idle(40);
    check(expQ.size() == 0, "R2 all results seen", expQ.size(), 0);
    check(bitOutValid == 1'b0, "R2 idle at end", bitOutValid, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule